// File: doc/BRIEF.md
# Latched 4-to-16 Decoder/Demultiplexer

The block turns a 4-bit binary address into one of 16 active-low select lines. Before decoding, the address goes through a holding stage controlled by a latch-enable input. While that input is high the holding stage is open, and the selected line follows the live address in the same cycle. When the input drops, the held address is frozen, so the selection stays put however the address pins move afterwards.

A separate active-low enable acts only on the outputs. With the enable high, every line is high. With it low, the line picked by the current selection is low. The enable never touches the held address.

Feeding a serial data stream into the enable turns the block into a 1-to-16 demultiplexer. The address picks the destination line, and that line carries the data bit while all other lines stay high.

The holding stage is modelled synchronously. A register loads the address on each rising clock edge at which latch enable is high. While the latch is open, a bypass feeds the live address straight to the decoder.

Top module: `latched_decoder`

## Requirements
- R1: Asynchronous reset (rst_ni low) clears the held address to 0. With latch closed and enable low after reset, out_no equals 16'hFFFE (bit 0 low).
- R2: With latch_en_i high and en_ni low, out_no equals the inverse of a one-hot word with bit addr_i set, in the same cycle as addr_i changes. addr_i[0] is the least significant address bit, and output bit k belongs to address value k.
- R3: At no time is more than one bit of out_no low.
- R4: With latch_en_i low, the selection is the address sampled at the last rising clock edge at which latch_en_i was high. Changes of addr_i while closed do not change out_no.
- R5: With en_ni high, out_no is 16'hFFFF whatever the address or latch state.
- R6: en_ni has no effect on the held address. After the enable is toggled while the latch is closed, driving en_ni low again shows the same selection as before.
- R7: After the latch is reopened, out_no again tracks the live address, and the new value is held once the latch closes again.
- R8: Used as a demultiplexer with a fixed address, the selected output bit equals en_ni on every cycle and all other bits stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the held address loads on rising edges |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Binary address, bit 0 least significant |
| latch_en_i | input | 1 | High: latch open (transparent); low: address held |
| en_ni | input | 1 | Active-low output enable / demux data |
| out_no | output | 16 | Active-low one-of-sixteen outputs |

## Verification
A wrong held address is invisible while the latch is open. It shows at the ports in the first cycle in which the latch is closed and the enable is low: the low bit lands on the wrong line. That is why the tests close the latch and then move the address, toggle the enable and reset. A fault in the gating or the decode shows at once, in the same cycle, as a second low bit, a missing low bit, or a low bit while the enable is high.

// File: rtl/ldec_pkg.sv
package ldec_pkg;
  localparam int unsigned DEF_ADDR_W = 4;

  typedef enum logic {
    SEL_HELD = 1'b0,
    SEL_LIVE = 1'b1
  } sel_src_e;
endpackage

// File: rtl/ldec_addr_hold.sv
module ldec_addr_hold #(
  parameter int unsigned ADDR_W = ldec_pkg::DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              open_i,
  output logic [ADDR_W-1:0] held_o,
  output logic [ADDR_W-1:0] sel_o
);
  import ldec_pkg::*;

  sel_src_e src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_o <= '0;
    else if (open_i) held_o <= addr_i;
  end

  assign src = open_i ? SEL_LIVE : SEL_HELD;

  // transparent path while open, frozen value while closed
  always_comb begin
    unique case (src)
      SEL_LIVE: sel_o = addr_i;
      default:  sel_o = held_o;
    endcase
  end
endmodule

// File: rtl/ldec_onehot.sv
module ldec_onehot #(
  parameter int unsigned ADDR_W = ldec_pkg::DEF_ADDR_W,
  localparam int unsigned N_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] sel_i,
  output logic [N_OUT-1:0]  hot_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_line
    assign hot_o[k] = (sel_i == ADDR_W'(k));
  end
endmodule

// File: rtl/ldec_gate.sv
module ldec_gate #(
  parameter int unsigned N_OUT = 16
) (
  input  logic [N_OUT-1:0] hot_i,
  input  logic             en_ni,
  output logic [N_OUT-1:0] out_no
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_bit
    assign out_no[k] = en_ni | ~hot_i[k];
  end
endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int unsigned ADDR_W = ldec_pkg::DEF_ADDR_W,
  localparam int unsigned N_OUT = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              latch_en_i,
  input  logic              en_ni,
  output logic [N_OUT-1:0]  out_no
);
  logic [ADDR_W-1:0] held_addr;
  logic [ADDR_W-1:0] sel_addr;
  logic [N_OUT-1:0]  hot;

  ldec_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .open_i (latch_en_i),
    .held_o (held_addr),
    .sel_o  (sel_addr)
  );

  ldec_onehot #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i (sel_addr),
    .hot_o (hot)
  );

  ldec_gate #(.N_OUT(N_OUT)) u_gate (
    .hot_i  (hot),
    .en_ni  (en_ni),
    .out_no (out_no)
  );
endmodule

// File: rtl/latched_decoder_chk.sv
module latched_decoder_chk #(
  parameter int unsigned ADDR_W = ldec_pkg::DEF_ADDR_W,
  localparam int unsigned N_OUT = 1 << ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              latch_en_i,
  input logic              en_ni,
  input logic [N_OUT-1:0]  out_no,
  input logic [ADDR_W-1:0] held_i
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R3
  one_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~out_no) <= 1);

  // R5
  off_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |-> (out_no == {N_OUT{1'b1}}));

  // R2
  open_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && !en_ni) |-> (~out_no == ({{(N_OUT-1){1'b0}}, 1'b1} << addr_i)));

  // R4
  closed_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    ($past(!latch_en_i) && !latch_en_i && $past(!en_ni) && !en_ni) |-> $stable(out_no));

  // R6
  held_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $past(!latch_en_i) |-> $stable(held_i));

  // R7
  held_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $past(latch_en_i) |-> (held_i == $past(addr_i)));
endmodule

bind latched_decoder latched_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .latch_en_i (latch_en_i),
  .en_ni      (en_ni),
  .out_no     (out_no),
  .held_i     (held_addr)
);

// File: tb/latched_decoder_test.sv
module latched_decoder_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        le;
    logic        en_n;
    logic [3:0]  addr;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  // each row applied after a falling edge; the next rising edge loads the latch if le=1
  localparam vec_t VECS [23] = '{
    '{1'b1, 1'b0, 4'd0,  16'hFFFE, 8'd2},  // R2 sweep
    '{1'b1, 1'b0, 4'd1,  16'hFFFD, 8'd2},
    '{1'b1, 1'b0, 4'd2,  16'hFFFB, 8'd2},
    '{1'b1, 1'b0, 4'd3,  16'hFFF7, 8'd2},
    '{1'b1, 1'b0, 4'd4,  16'hFFEF, 8'd2},
    '{1'b1, 1'b0, 4'd5,  16'hFFDF, 8'd2},
    '{1'b1, 1'b0, 4'd6,  16'hFFBF, 8'd2},
    '{1'b1, 1'b0, 4'd7,  16'hFF7F, 8'd2},
    '{1'b1, 1'b0, 4'd8,  16'hFEFF, 8'd2},
    '{1'b1, 1'b0, 4'd9,  16'hFDFF, 8'd2},
    '{1'b1, 1'b0, 4'd10, 16'hFBFF, 8'd2},
    '{1'b1, 1'b0, 4'd11, 16'hF7FF, 8'd2},
    '{1'b1, 1'b0, 4'd12, 16'hEFFF, 8'd2},
    '{1'b1, 1'b0, 4'd13, 16'hDFFF, 8'd2},
    '{1'b1, 1'b0, 4'd14, 16'hBFFF, 8'd2},
    '{1'b1, 1'b0, 4'd15, 16'h7FFF, 8'd2},
    '{1'b0, 1'b0, 4'd3,  16'h7FFF, 8'd4},  // R4 held at 15
    '{1'b0, 1'b0, 4'd9,  16'h7FFF, 8'd4},
    '{1'b0, 1'b1, 4'd9,  16'hFFFF, 8'd5},  // R5
    '{1'b0, 1'b0, 4'd0,  16'h7FFF, 8'd6},  // R6 still 15
    '{1'b1, 1'b0, 4'd5,  16'hFFDF, 8'd7},  // R7 reopen
    '{1'b0, 1'b1, 4'd12, 16'hFFFF, 8'd5},
    '{1'b0, 1'b0, 4'd12, 16'hFFDF, 8'd7}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        le = 1'b0;
  logic        en_n = 1'b1;
  logic [15:0] out_n;
  int checks = 0;
  int errors = 0;

  latched_decoder uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .addr_i     (addr),
    .latch_en_i (le),
    .en_ni      (en_n),
    .out_no     (out_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_one_low(input string tag);
    checks++;
    if ($countones(~out_n) > 1) begin
      errors++;
      $display("FAIL %s actual %h expected at most one low bit", tag, out_n);
    end
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD*2 + 1);
    en_n = 1'b0;
    #1 chk("R1 reset closed", out_n, 16'hFFFE);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R1 after release", out_n, 16'hFFFE);

    foreach (VECS[i]) begin
      @(negedge clk);
      le = VECS[i].le; en_n = VECS[i].en_n; addr = VECS[i].addr;
      #1 chk($sformatf("R%0d vec %0d", VECS[i].req, i), out_n, VECS[i].exp);
      chk_one_low("R3 one low");
    end

    // R2 same-cycle transparency: two address changes between edges
    @(negedge clk);
    le = 1'b1; en_n = 1'b0; addr = 4'd10;
    #1 chk("R2 live a", out_n, 16'hFBFF);
    addr = 4'd1;
    #1 chk("R2 live b", out_n, 16'hFFFD);

    // R8 demux on line 6 with serial data
    @(negedge clk);
    le = 1'b0; addr = 4'd6;
    @(negedge clk);
    le = 1'b1;
    @(negedge clk);
    le = 1'b0; addr = 4'd2;
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      en_n = (b % 3 != 1);
      #1 chk("R8 demux", out_n, en_n ? 16'hFFFF : 16'hFFBF);
    end

    // R1 async reset mid-run with latch closed
    @(negedge clk);
    en_n = 1'b0;
    #1 chk("R1 before reset held 6", out_n, 16'hFFBF);
    rst_n = 1'b0;
    #1 chk("R1 async reset", out_n, 16'hFFFE);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R1 post reset", out_n, 16'hFFFE);

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule